// File: doc/BRIEF.md
# SSI Master with Double-Read Verification

This block is the controller end of a Synchronous Serial Interface link to an absolute position sensor. When a start request arrives while the data line rests high, it drives a burst of clock pulses and shifts in one frame, with the most significant bit first. The frame length and the clock half-period are configuration inputs. As soon as the frame ends, it waits a short fixed gap and then clocks a second frame. The gap is short enough that the sensor still holds its output low after the first transfer, so it sends the same stored word again.

The two received words are compared. The block then gives the first word together with a one-cycle valid strobe. It raises an error flag when the words differ, when the data line is not low right after a frame, or when a start request finds the line low while idle. After the double read it stays busy for a fixed recovery time, so that the sensor's hold timer runs out before the next transaction. Line drivers and the meaning of the position bits belong elsewhere.

Top module: `ssi_dual_read_master`

## Requirements
- R1: The serial clock output rests at 1 whenever the block is not busy. After a start is accepted, each frame is made of N bit periods. Each bit period holds the clock at 0 for H system cycles and then at 1 for H system cycles, so every bit period opens with a falling edge. The first low cycle is the cycle right after the accepting edge.
- R2: The data line is sampled once per bit period, on the last system cycle of the high half. Received bits shift in MSB first. The word is right-aligned on the word output, and the bits above N read 0.
- R3: The frame length N (for example 13, 14, 25 or 26) and the half-period H are captured from the configuration inputs when a start is accepted. A length of 0 is treated as 1, a length above MAX_BITS is treated as MAX_BITS, and a half-period of 0 is treated as 1.
- R4: After the check cycle of the first frame, the clock stays at 1 for exactly GAP_CYC cycles. The second frame then begins with the same N and H.
- R5: If the two received words differ, bit 1 (mismatch) of the error code is set.
- R6: In the single system cycle that follows the last sample of each frame, the data line must read 0. If it reads 1 after either frame, bit 0 (line fault) of the error code is set.
- R7: A start request in idle while the data line reads 0 is refused. Busy stays low, and on the next cycle the error code reads 01 with the error flag high.
- R8: The valid strobe is high for exactly one cycle, 4·N·H + GAP_CYC + 3 cycles after the accepting edge. In that cycle the word output carries the first frame's word, and the error code takes its new value in that same cycle.
- R9: The error flag equals the OR of the two error-code bits. The error code holds its value until the next start request is sampled in idle, which clears it (or sets 01 under R7).
- R10: Busy stays high from the accepting edge through REC_CYC cycles after the valid strobe appears. Start requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| sdata_i | input | 1 | Serial data line from the sensor |
| cfg_bits_i | input | $clog2(MAX_BITS+1) | Frame length in bits |
| cfg_half_i | input | HALF_W | Clock half-period in system cycles |
| sclk_o | output | 1 | Serial clock to the sensor, rests high |
| busy_o | output | 1 | Transaction or recovery in progress |
| word_o | output | MAX_BITS | Position word from the first read |
| valid_o | output | 1 | One-cycle strobe that marks a new word |
| err_o | output | 1 | Error present |
| err_code_o | output | 2 | Bit 1 mismatch, bit 0 line fault |

## Verification
If the bit counter or the phase timer goes wrong, the serial clock pattern departs from the expected waveform in the very cycle it happens. Because the bench compares that pattern on every clock, such a fault shows up at once, long before the valid strobe. Faults in the capture path, such as a wrong sample point, a wrong shift direction, or a first word that was not stored, stay hidden until the strobe. They then show up as a wrong word or a wrong error code at the cycle predicted by R8. A stale pending-error state shows up at the next strobe, or as an error code that is not cleared at the following start.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_CHK,
        ST_GAP,
        ST_REC
    } ssi_state_e;

    typedef struct packed {
        logic mismatch;
        logic line;
    } ssi_err_t;

    localparam ssi_err_t ERR_NONE = '{mismatch: 1'b0, line: 1'b0};
    localparam ssi_err_t ERR_LINE = '{mismatch: 1'b0, line: 1'b1};

    function automatic ssi_err_t err_merge(input ssi_err_t a, input ssi_err_t b);
        ssi_err_t r;
        r.mismatch = a.mismatch | b.mismatch;
        r.line     = a.line | b.line;
        return r;
    endfunction

endpackage

// File: rtl/ssi_phase_timer.sv
module ssi_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] span,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign expire = (cnt_q == span - 1'b1);
endmodule

// File: rtl/ssi_rx_shift.sv
module ssi_rx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clr) word <= '0;
        else if (en)    word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/ssi_frame_cmp.sv
module ssi_frame_cmp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         store,
    input  logic [W-1:0] cur,
    output logic [W-1:0] first,
    output logic         same
);
    logic [W-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst)        first <= '0;
        else if (store) first <= cur;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = first[i] ^ cur[i];
    end

    assign same = ~|diff;
endmodule

// File: rtl/ssi_dual_read_master.sv
module ssi_dual_read_master
    import ssi_pkg::*;
#(
    parameter int MAX_BITS = 32,
    parameter int HALF_W   = 8,
    parameter int CNT_W    = 16,
    parameter int GAP_CYC  = 200,
    parameter int REC_CYC  = 3500,
    localparam int BITS_W  = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                sdata_i,
    input  logic [BITS_W-1:0]   cfg_bits_i,
    input  logic [HALF_W-1:0]   cfg_half_i,
    output logic                sclk_o,
    output logic                busy_o,
    output logic [MAX_BITS-1:0] word_o,
    output logic                valid_o,
    output logic                err_o,
    output logic [1:0]          err_code_o
);
    localparam logic [CNT_W-1:0]  GAP_SPAN = CNT_W'(GAP_CYC);
    localparam logic [CNT_W-1:0]  REC_SPAN = CNT_W'(REC_CYC);
    localparam logic [BITS_W-1:0] MAX_LEN  = BITS_W'(MAX_BITS);

    ssi_state_e st_q, st_d;
    logic [BITS_W-1:0]   nbits_q, bitcnt_q, nbits_sel;
    logic [HALF_W-1:0]   half_q, half_sel;
    logic                second_q;
    ssi_err_t            pend_q, err_q, chk_err;
    logic                valid_q;
    logic [MAX_BITS-1:0] word_q;

    logic [CNT_W-1:0]    span;
    logic                t_exp;
    logic                accept, refuse, bit_end, last_bit, in_chk;
    logic                shift_clr, store_first, same;
    logic [MAX_BITS-1:0] rx_word, first_word;

    // Configuration capture with range limits.
    always_comb begin
        if (cfg_bits_i == '0)          nbits_sel = BITS_W'(1);
        else if (cfg_bits_i > MAX_LEN) nbits_sel = MAX_LEN;
        else                           nbits_sel = cfg_bits_i;
        half_sel = (cfg_half_i == '0) ? HALF_W'(1) : cfg_half_i;
    end

    assign accept      = (st_q == ST_IDLE) && start_i && sdata_i;
    assign refuse      = (st_q == ST_IDLE) && start_i && !sdata_i;
    assign bit_end     = (st_q == ST_HIGH) && t_exp;
    assign last_bit    = bit_end && (bitcnt_q == nbits_q - 1'b1);
    assign in_chk      = (st_q == ST_CHK);
    assign store_first = in_chk && !second_q;
    assign shift_clr   = accept || store_first;

    always_comb begin
        chk_err      = ERR_NONE;
        chk_err.line = in_chk && sdata_i;
    end

    // Span of the current phase.
    always_comb begin
        unique case (st_q)
            ST_GAP:  span = GAP_SPAN;
            ST_REC:  span = REC_SPAN;
            default: span = CNT_W'(half_q);
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = ST_LOW;
            ST_LOW:  if (t_exp) st_d = ST_HIGH;
            ST_HIGH: if (t_exp) st_d = last_bit ? ST_CHK : ST_LOW;
            ST_CHK:  st_d = second_q ? ST_REC : ST_GAP;
            ST_GAP:  if (t_exp) st_d = ST_LOW;
            ST_REC:  if (t_exp) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    ssi_phase_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (st_d != st_q),
        .span    (span),
        .expire  (t_exp)
    );

    ssi_rx_shift #(.W(MAX_BITS)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .clr  (shift_clr),
        .en   (bit_end),
        .din  (sdata_i),
        .word (rx_word)
    );

    ssi_frame_cmp #(.W(MAX_BITS)) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .store (store_first),
        .cur   (rx_word),
        .first (first_word),
        .same  (same)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            nbits_q  <= BITS_W'(1);
            half_q   <= HALF_W'(1);
            bitcnt_q <= '0;
            second_q <= 1'b0;
            pend_q   <= ERR_NONE;
            err_q    <= ERR_NONE;
            valid_q  <= 1'b0;
            word_q   <= '0;
        end else begin
            st_q    <= st_d;
            valid_q <= 1'b0;
            if (accept) begin
                nbits_q  <= nbits_sel;
                half_q   <= half_sel;
                bitcnt_q <= '0;
                second_q <= 1'b0;
                pend_q   <= ERR_NONE;
                err_q    <= ERR_NONE;
            end else if (refuse) begin
                err_q <= ERR_LINE;
            end
            if (bit_end) bitcnt_q <= bitcnt_q + 1'b1;
            if (in_chk) begin
                bitcnt_q <= '0;
                if (!second_q) begin
                    second_q <= 1'b1;
                    pend_q   <= err_merge(pend_q, chk_err);
                end else begin
                    err_q          <= err_merge(pend_q, chk_err);
                    err_q.mismatch <= pend_q.mismatch | !same;
                    word_q         <= first_word;
                    valid_q        <= 1'b1;
                end
            end
        end
    end

    assign sclk_o     = (st_q != ST_LOW);
    assign busy_o     = (st_q != ST_IDLE);
    assign word_o     = word_q;
    assign valid_o    = valid_q;
    assign err_code_o = {err_q.mismatch, err_q.line};
    assign err_o      = err_q.mismatch | err_q.line;
endmodule

// File: rtl/ssi_dual_read_master_chk.sv
module ssi_dual_read_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       sdata_i,
    input logic       sclk_o,
    input logic       busy_o,
    input logic       valid_o,
    input logic       err_o,
    input logic [1:0] err_code_o
);
    AST_SCLK_REST_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> sclk_o); // R1

    AST_START_OPENS_LOW: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && sdata_i) |=> (busy_o && !sclk_o)); // R1

    AST_REFUSED_START: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !sdata_i) |=> (!busy_o && err_code_o == 2'b01)); // R7

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R8

    AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> busy_o); // R10

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(start_i) && !valid_o) |-> $stable(err_code_o)); // R9

    AST_ERR_FLAG_CODE: assert property (@(posedge clk) disable iff (rst)
        err_o == (err_code_o != 2'b00)); // R9
endmodule

bind ssi_dual_read_master ssi_dual_read_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .sdata_i    (sdata_i),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .err_o      (err_o),
    .err_code_o (err_code_o)
);

// File: tb/ssi_dual_read_master_bench.sv
module ssi_dual_read_master_bench;
    localparam int MAXB = 32;
    localparam int GAP  = 6;
    localparam int REC  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        enc_line = 1'b1;
    logic        force_low = 1'b0;
    logic        sdata_i;
    logic [5:0]  cfg_bits = 6'd13;
    logic [7:0]  cfg_half = 8'd2;
    logic        sclk_o, busy_o, valid_o, err_o;
    logic [MAXB-1:0] word_o;
    logic [1:0]  err_code_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    assign sdata_i = force_low ? 1'b0 : enc_line;

    always #5 clk = ~clk;

    ssi_dual_read_master #(
        .MAX_BITS (MAXB), .HALF_W (8), .CNT_W (16),
        .GAP_CYC (GAP), .REC_CYC (REC)
    ) u_ssi_dual_read_master (
        .clk (clk), .rst (rst), .start_i (start_i), .sdata_i (sdata_i),
        .cfg_bits_i (cfg_bits), .cfg_half_i (cfg_half),
        .sclk_o (sclk_o), .busy_o (busy_o), .word_o (word_o),
        .valid_o (valid_o), .err_o (err_o), .err_code_o (err_code_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Sensor model: latches on a falling edge when idle, shifts on rising
    // edges, holds low after a frame and repeats the stored word if clocked
    // again during the hold.
    logic [31:0] enc_pos = 32'h0;
    int  hold_len = 20;
    bit  stuck = 0;
    logic [31:0] s_latch;
    int  s_state, s_b, s_e, s_h;
    logic s_prev;

    always @(negedge clk) begin
        if (rst) begin
            enc_line = 1'b1; s_state = 0; s_prev = 1'b1;
        end else begin
            bit fall, rise;
            fall = s_prev && !sclk_o;
            rise = !s_prev && sclk_o;
            s_prev = sclk_o;
            case (s_state)
                0: if (fall) begin s_latch = enc_pos; s_b = 0; s_state = 1; end
                1: if (rise) begin
                       enc_line = s_latch[int'(cfg_bits) - 1 - s_b];
                       s_b++;
                       if (s_b == int'(cfg_bits)) begin s_e = 0; s_state = 2; end
                   end
                2: begin
                       s_e++;
                       if (s_e == int'(cfg_half)) begin
                           enc_line = stuck; s_h = 0; s_state = 3;
                       end
                   end
                default: if (fall) begin s_b = 0; s_state = 1; end
                         else begin
                             s_h++;
                             if (s_h >= hold_len) begin enc_line = 1'b1; s_state = 0; end
                         end
            endcase
        end
    end

    // Behavioural reference of the port timing.
    bit  m_act = 0;
    int  m_idx, m_n, m_h, m_f, m_vidx, m_last;
    logic [1:0] m_code = 2'b00;
    logic [1:0] scen_code = 2'b00;
    logic [31:0] scen_word = 32'h0;

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_idx = 0; m_code = 2'b00;
        end else if (m_act) begin
            if (m_idx == m_last) m_act = 0;
            else begin
                m_idx++;
                if (m_idx == m_vidx) m_code = scen_code;
            end
        end else if (start_i) begin
            if (sdata_i) begin
                m_act = 1; m_idx = 1;
                m_n = int'(cfg_bits); m_h = int'(cfg_half);
                m_f = 2 * m_n * m_h;
                m_vidx = 2 * m_f + GAP + 3;
                m_last = m_vidx + REC - 1;
                m_code = 2'b00;
            end else m_code = 2'b01;
        end
    end

    function automatic bit exp_sclk();
        int p;
        if (!m_act) return 1'b1;
        if (m_idx <= m_f) begin
            p = (m_idx - 1) % (2 * m_h);
            return p >= m_h;
        end
        if (m_idx <= m_f + 1 + GAP) return 1'b1;
        if (m_idx <= 2 * m_f + 1 + GAP) begin
            p = (m_idx - (m_f + 2 + GAP)) % (2 * m_h);
            return p >= m_h;
        end
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ev;
            ev = m_act && (m_idx == m_vidx);
            check(sclk_o == exp_sclk(), "R1 R4 sclk", sclk_o, exp_sclk());
            check(busy_o == m_act, "R10 busy", busy_o, m_act);
            check(valid_o == ev, "R8 valid", valid_o, ev);
            check(err_code_o == m_code, "R5 R6 R9 err_code", err_code_o, m_code);
            check(err_o == (m_code != 0), "R9 err", err_o, m_code != 0);
            if (ev)
                check(word_o == scen_word, "R2 R3 word", word_o, scen_word);
        end
    end

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_act) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input int n, input int h, input logic [31:0] pos, input logic [1:0] code);
        cfg_bits = 6'(n); cfg_half = 8'(h); enc_pos = pos;
        scen_word = pos & ((32'h1 << n) - 1);
        scen_code = code;
        pulse_start();
        wait_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(sclk_o == 1'b1 && busy_o == 1'b0, "R1 R10 reset idle", {sclk_o, busy_o}, 2'b10);
        check(valid_o == 1'b0 && err_o == 1'b0, "R8 R9 reset outputs", {valid_o, err_o}, 2'b00);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        run(13, 2, 32'h0000_1ABC, 2'b00);       // R3 single-turn length
        run(14, 1, 32'h0000_2AA5, 2'b00);
        run(25, 1, 32'h01F0_0F31, 2'b00);       // R3 multi-turn length
        run(26, 3, 32'h02C3_5A96, 2'b00);

        // R10: a start in mid-transaction is ignored.
        cfg_bits = 6'd13; cfg_half = 8'd2; enc_pos = 32'h0000_0F0F;
        scen_word = 32'h0000_0F0F; scen_code = 2'b00;
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        wait_idle();

        // R5: short hold, sensor latches a new value for the second read.
        hold_len = 3;
        cfg_bits = 6'd14; cfg_half = 8'd2; enc_pos = 32'h0000_1234;
        scen_word = 32'h0000_1234; scen_code = 2'b10;
        pulse_start();
        repeat (3) @(negedge clk);
        enc_pos = 32'h0000_1235;
        wait_idle();
        hold_len = 20;
        // R9: error still held while idle
        repeat (5) @(negedge clk);
        check(err_code_o == 2'b10, "R9 held mismatch", err_code_o, 2'b10);

        // R6: line never drops after the frames.
        stuck = 1;
        run(13, 1, 32'h0000_0777, 2'b01);
        stuck = 0;
        repeat (25) @(negedge clk);

        // R7: start refused with the line low.
        force_low = 1'b1;
        pulse_start();
        repeat (2) @(negedge clk);
        check(busy_o == 1'b0 && err_code_o == 2'b01, "R7 refused start", {busy_o, err_code_o}, 3'b001);
        force_low = 1'b0;
        repeat (3) @(negedge clk);

        // R9: a good transaction clears the error at its start.
        run(13, 2, 32'h0000_1555, 2'b00);
        check(err_o == 1'b0, "R9 cleared", err_o, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule